// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block is the memory-mapped register front end of an interrupt distributor. It decodes word and double-word accesses from a simple valid/ready register bus. It holds the one writable global enable bit and a 24-bit affinity value for every shared interrupt. Everything else is served as read-only words built from parameters: the control flags that always read one, the type word, the identification word and the ID register window.

When software turns the distributor on, the block sends a single-cycle wake pulse so that every CPU re-examines its pending work. Turning it on again while it is already on sends nothing. Routing entries exist for all 1024 interrupt numbers. The 32 private numbers, and any number above the configured shared range, read as zero and ignore writes. Pending state, priority arbitration and the CPU interface live elsewhere.

Every request is accepted at once. Its response, with read data, comes back exactly one cycle later. Offsets that are not mapped are acknowledged like any other access.

Top module: `irq_dist_regs`

## Requirements
- R1: The control word at offset 0x0000 has one writable enable bit at bit 0. Bits 4 (affinity routing) and 6 (security disabled) always read one, and every other bit reads zero.
- R2: A write to the control word with bit 0 set while the enable bit is 0 drives wakePulse high for exactly the one cycle after the write is accepted. A write of 1 while already enabled, or a write of 0, produces no pulse.
- R3: The type word at offset 0x0004 reads bits [4:0] = (32 + NUM_SHARED)/32 - 1 and bits [23:19] = ID_BITS - 1, with all other bits zero. Writes to it are ignored.
- R4: The identification word at offset 0x0008 reads the IDENT_WORD parameter. Writes to it are ignored.
- R5: Routing entry n sits at offset 0x6000 + 8n. For a shared interrupt (32 <= n < 32 + NUM_SHARED), a 4- or 8-byte write to the entry's base offset stores write data bits [23:0]. A read returns that value with all higher bits zero.
- R6: The upper half of a routing entry (base offset + 4) reads zero and ignores writes. An 8-byte read of an entry returns zero in bits [63:32].
- R7: Routing entries for n < 32 (private) and for n >= 32 + NUM_SHARED read zero and ignore writes.
- R8: The ID window spans 0xFFD0 to 0xFFFC. Offset 0xFFE8 reads 0x3B, every other offset in the window reads zero, and writes to the window are ignored.
- R9: reqReady is always 1. Each accepted request raises rspValid in the following cycle. rspRdata carries read data only in that cycle and is zero otherwise, including in the response to a write.
- R10: An access to an unmapped offset reads zero and changes no stored state.
- R11: Reset clears the enable bit and every routing entry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted (always 1) |
| reqAddr | input | 16 | Byte offset of the access (low two bits ignored) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reqWdata | input | 64 | Write data |
| rspValid | output | 1 | Response for the request of the previous cycle |
| rspRdata | output | 64 | Read data, zero when not a read response |
| wakePulse | output | 1 | One-cycle pulse on an enable rising edge |

## Verification
A wrong enable bit shows up in the very next control-word read as bit 0. It also shows at wakePulse: the cycle after the next enabling write carries a missing or extra pulse. A corrupted or misdecoded routing entry shows only when that entry is read back, so the random phase reads entries over and over against a model. It also writes to neighbouring, private and out-of-range entries, so that a write landing in the wrong place shows up in a later read. A wrong decode of the read-only words or of the upper half shows in the response of the same read, one cycle after the request.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  localparam int ROUTE_IDX_W  = 10;       // 1024 interrupt numbers
  localparam int AFF_W        = 24;
  localparam int PRIVATE_CNT  = 32;
  localparam logic [15:0] OFS_CTL    = 16'h0000;
  localparam logic [15:0] OFS_TYPE   = 16'h0004;
  localparam logic [15:0] OFS_IDENT  = 16'h0008;
  localparam logic [2:0]  ROUTE_TAG  = 3'b011; // 0x6000..0x7FFF
  localparam logic [15:0] OFS_IDWIN  = 16'hFFD0;
  localparam logic [15:0] OFS_PID2   = 16'hFFE8;
  localparam logic [31:0] PID2_VALUE = 32'h0000_003B;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_ARE_BIT  = 4;
  localparam int CTL_DS_BIT   = 6;

  typedef enum logic [2:0] {
    RD_ZERO, RD_CTL, RD_TYPE, RD_IDENT, RD_ROUTE, RD_PID2
  } rdSel_e;

  typedef struct packed {
    logic                   ctlWr;
    logic                   routeWr;
    logic                   rspLoad;
    logic                   rdLoad;
    rdSel_e                 rdSel;
    logic [ROUTE_IDX_W-1:0] routeIdx;   // shared index (n - 32)
  } strobe_t;

endpackage

// File: rtl/irq_dist_ctrl.sv
module irq_dist_ctrl
  import irq_dist_pkg::*;
#(
  parameter int NUM_SHARED = 64
) (
  input  logic        reqValid,
  input  logic [15:0] reqAddr,
  input  logic        reqWrite,
  output strobe_t     strobe
);

  localparam int SHARED_LIMIT = PRIVATE_CNT + NUM_SHARED;

  logic [15:0]            wordAddr;
  logic                   routeHit;
  logic                   routeUpper;
  logic [ROUTE_IDX_W-1:0] rawIdx;
  logic                   sharedHit;
  logic                   isRead;
  logic                   isWrite;

  assign wordAddr   = {reqAddr[15:2], 2'b00};
  assign routeHit   = (wordAddr[15:13] == ROUTE_TAG);
  assign routeUpper = wordAddr[2];
  assign rawIdx     = wordAddr[12:3];
  assign sharedHit  = (32'(rawIdx) >= PRIVATE_CNT) && (32'(rawIdx) < SHARED_LIMIT);
  assign isRead     = reqValid && !reqWrite;
  assign isWrite    = reqValid && reqWrite;

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_ZERO;
    strobe.rspLoad  = reqValid;
    strobe.rdLoad   = isRead;
    strobe.routeIdx = rawIdx - ROUTE_IDX_W'(PRIVATE_CNT);
    if (wordAddr == OFS_CTL) begin
      strobe.rdSel = RD_CTL;
      strobe.ctlWr = isWrite;
    end else if (wordAddr == OFS_TYPE) begin
      strobe.rdSel = RD_TYPE;
    end else if (wordAddr == OFS_IDENT) begin
      strobe.rdSel = RD_IDENT;
    end else if (routeHit && sharedHit && !routeUpper) begin
      strobe.rdSel   = RD_ROUTE;
      strobe.routeWr = isWrite;
    end else if (wordAddr == OFS_PID2) begin
      strobe.rdSel = RD_PID2;
    end
  end

endmodule

// File: rtl/irq_dist_data.sv
module irq_dist_data
  import irq_dist_pkg::*;
#(
  parameter int          NUM_SHARED = 64,
  parameter int          ID_BITS    = 10,
  parameter logic [31:0] IDENT_WORD = 32'h0200_143B
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strobe,
  input  logic [AFF_W-1:0] wrAff,
  output logic        rspValid,
  output logic [63:0] rspRdata,
  output logic        wakePulse
);

  localparam int TOTAL_IRQ = PRIVATE_CNT + NUM_SHARED;
  localparam int LINE_FLD  = TOTAL_IRQ / 32 - 1;
  localparam logic [31:0] TYPE_WORD =
    32'(LINE_FLD) | (32'(ID_BITS - 1) << 19);

  logic             enableQ;
  logic [AFF_W-1:0] routeQ [NUM_SHARED];
  logic [AFF_W-1:0] routeRd;
  logic [31:0]      ctlWord;
  logic [31:0]      rdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ   <= 1'b0;
      wakePulse <= 1'b0;
    end else begin
      wakePulse <= strobe.ctlWr && wrAff[CTL_EN_BIT] && !enableQ;
      if (strobe.ctlWr) enableQ <= wrAff[CTL_EN_BIT];
    end
  end

  for (genvar g = 0; g < NUM_SHARED; g++) begin : g_route
    always_ff @(posedge clk) begin
      if (!rstN)
        routeQ[g] <= '0;
      else if (strobe.routeWr && strobe.routeIdx == ROUTE_IDX_W'(g))
        routeQ[g] <= wrAff;
    end
  end

  always_comb begin
    routeRd = '0;
    for (int i = 0; i < NUM_SHARED; i++)
      if (strobe.routeIdx == ROUTE_IDX_W'(i)) routeRd = routeQ[i];
  end

  always_comb begin
    ctlWord = '0;
    ctlWord[CTL_EN_BIT]  = enableQ;
    ctlWord[CTL_ARE_BIT] = 1'b1;
    ctlWord[CTL_DS_BIT]  = 1'b1;
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_CTL:   rdWord = ctlWord;
      RD_TYPE:  rdWord = TYPE_WORD;
      RD_IDENT: rdWord = IDENT_WORD;
      RD_ROUTE: rdWord = 32'(routeRd);
      RD_PID2:  rdWord = PID2_VALUE;
      default:  rdWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobe.rspLoad;
      rspRdata <= strobe.rdLoad ? {32'h0, rdWord} : 64'h0;
    end
  end

endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int          NUM_SHARED = 64,
  parameter int          ID_BITS    = 10,
  parameter logic [31:0] IDENT_WORD = 32'h0200_143B
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [15:0] reqAddr,
  input  logic        reqWrite,
  input  logic        reqSize8,
  input  logic [63:0] reqWdata,
  output logic        rspValid,
  output logic [63:0] rspRdata,
  output logic        wakePulse
);

  strobe_t strobe;
  logic    unusedTopBits;

  // Size only matters for which half is touched; the upper 32 bits of an
  // 8-byte access are never stored, so both sizes share one path.
  assign unusedTopBits = ^{reqSize8, reqWdata[63:AFF_W]};
  assign reqReady = 1'b1;

  irq_dist_ctrl #(.NUM_SHARED(NUM_SHARED)) i_ctrl (
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .strobe   (strobe)
  );

  irq_dist_data #(
    .NUM_SHARED (NUM_SHARED),
    .ID_BITS    (ID_BITS),
    .IDENT_WORD (IDENT_WORD)
  ) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrAff     (reqWdata[AFF_W-1:0]),
    .rspValid  (rspValid),
    .rspRdata  (rspRdata),
    .wakePulse (wakePulse)
  );

endmodule

// File: rtl/irq_dist_regs_chk.sv
module irq_dist_regs_chk #(
  parameter int NUM_SHARED = 64,
  parameter int ID_BITS    = 10
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [15:0] reqAddr,
  input logic        reqWrite,
  input logic [63:0] reqWdata,
  input logic        rspValid,
  input logic [63:0] rspRdata,
  input logic        wakePulse
);

  localparam logic [63:0] TYPE_EXP =
    64'((PRIVATE_LINES + NUM_SHARED / 32) - 1) | (64'(ID_BITS - 1) << 19);
  localparam int PRIVATE_LINES = 1;

  logic unusedChk;
  assign unusedChk = ^reqWdata[63:1];

  logic ctlRead, typeRead, upperRead, ctlEnWrite;
  assign ctlRead    = reqValid && !reqWrite && reqAddr[15:2] == 14'h0000;
  assign typeRead   = reqValid && !reqWrite && reqAddr[15:2] == 14'h0001;
  assign upperRead  = reqValid && !reqWrite && reqAddr[15:13] == 3'b011 && reqAddr[2];
  assign ctlEnWrite = reqValid && reqWrite && reqAddr[15:2] == 14'h0000 && reqWdata[0];

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rstN) reqReady);
  assert_rsp_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && rspRdata == 64'h0));
  assert_wake_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);
  assert_wake_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakePulse) |-> $past(ctlEnWrite));
  assert_ctl_fixed_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctlRead |=> (rspRdata & ~64'h1) == 64'h50);
  assert_type_value_R3: assert property (@(posedge clk) disable iff (!rstN)
    typeRead |=> rspRdata == TYPE_EXP);
  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    upperRead |=> rspRdata == 64'h0);

endmodule

bind irq_dist_regs irq_dist_regs_chk #(
  .NUM_SHARED (NUM_SHARED),
  .ID_BITS    (ID_BITS)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqAddr   (reqAddr),
  .reqWrite  (reqWrite),
  .reqWdata  (reqWdata),
  .rspValid  (rspValid),
  .rspRdata  (rspRdata),
  .wakePulse (wakePulse)
);

// File: tb/test_irq_dist_regs.sv
module test_irq_dist_regs;

  localparam int NUM_SHARED = 64;
  localparam int ID_BITS    = 10;
  localparam logic [31:0] IDENT = 32'h0200_143B;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqSize8 = 1'b0;
  logic [63:0] reqWdata = '0;
  logic        rspValid;
  logic [63:0] rspRdata;
  logic        wakePulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [23:0] model [NUM_SHARED];
  logic        enModel = 1'b0;

  always #2.5 clk = ~clk;

  irq_dist_regs #(.NUM_SHARED(NUM_SHARED), .ID_BITS(ID_BITS), .IDENT_WORD(IDENT))
    i_irq_dist_regs (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] routeAddr(input int n, input bit upper);
    return 16'h6000 + 16'(n * 8) + (upper ? 16'd4 : 16'd0);
  endfunction

  // expected read value from requirements R1,R3-R8,R10
  function automatic logic [63:0] expRead(input logic [15:0] a);
    logic [15:0] w = {a[15:2], 2'b00};
    if (w == 16'h0000) return 64'h50 | 64'(enModel);
    if (w == 16'h0004) return 64'((32 + NUM_SHARED) / 32 - 1) | (64'(ID_BITS - 1) << 19);
    if (w == 16'h0008) return 64'(IDENT);
    if (w == 16'hFFE8) return 64'h3B;
    if (w[15:13] == 3'b011 && !w[2]) begin
      int n = int'(w[12:3]);
      if (n >= 32 && n < 32 + NUM_SHARED) return 64'(model[n - 32]);
    end
    return 64'h0;
  endfunction

  // model update for writes (R2,R5,R7)
  function automatic logic expWrite(input logic [15:0] a, input logic [63:0] d);
    logic [15:0] w = {a[15:2], 2'b00};
    logic wake = 1'b0;
    if (w == 16'h0000) begin
      wake = d[0] && !enModel;
      enModel = d[0];
    end else if (w[15:13] == 3'b011 && !w[2]) begin
      int n = int'(w[12:3]);
      if (n >= 32 && n < 32 + NUM_SHARED) model[n - 32] = d[23:0];
    end
    return wake;
  endfunction

  task automatic acc(input logic wr, input logic [15:0] a, input logic s8,
                     input logic [63:0] d, output logic [63:0] rd, output logic wk);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize8 = s8; reqWdata = d;
    @(posedge clk);
    #1;
    check("R9 rspValid", 64'(rspValid), 64'h1);
    rd = rspRdata; wk = wakePulse;
    reqValid = 1'b0;
  endtask

  task automatic wrChk(input string req, input logic [15:0] a, input logic s8, input logic [63:0] d);
    logic [63:0] rd; logic wk; logic ew;
    ew = expWrite(a, d);
    acc(1'b1, a, s8, d, rd, wk);
    check({req, " write rdata"}, rd, 64'h0);
    check({req, " R2 wake"}, 64'(wk), 64'(ew));
  endtask

  task automatic rdChk(input string req, input logic [15:0] a, input logic s8);
    logic [63:0] rd; logic wk;
    acc(1'b0, a, s8, 64'h0, rd, wk);
    check(req, rd, expRead(a));
    check({req, " R2 no wake"}, 64'(wk), 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NUM_SHARED; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check("R11 wake after reset", 64'(wakePulse), 64'h0);
    check("R9 ready", 64'(reqReady), 64'h1);

    rdChk("R11 R1 control reset", 16'h0000, 1'b0);
    rdChk("R11 route reset", routeAddr(40, 0), 1'b1);
    wrChk("R2 enable rise", 16'h0000, 1'b0, 64'h1);
    rdChk("R1 control enabled", 16'h0000, 1'b0);
    wrChk("R2 enable again", 16'h0000, 1'b0, 64'hFFFF_FFFF);
    wrChk("R2 disable", 16'h0000, 1'b0, 64'h0);
    rdChk("R1 control disabled", 16'h0000, 1'b0);
    wrChk("R2 enable rise 8B", 16'h0000, 1'b1, 64'hFFFF_0000_0000_0001);

    rdChk("R3 type", 16'h0004, 1'b0);
    wrChk("R3 type write", 16'h0004, 1'b0, 64'h1234_5678);
    rdChk("R3 type after write", 16'h0004, 1'b0);
    rdChk("R4 ident", 16'h0008, 1'b0);
    wrChk("R4 ident write", 16'h0008, 1'b0, 64'h0);
    rdChk("R4 ident after write", 16'h0008, 1'b0);

    wrChk("R5 first shared", routeAddr(32, 0), 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rdChk("R5 R6 first shared 8B", routeAddr(32, 0), 1'b1);
    rdChk("R6 upper read", routeAddr(32, 1), 1'b0);
    wrChk("R6 upper write", routeAddr(32, 1), 1'b0, 64'hAAAA_AAAA);
    rdChk("R6 lower unchanged", routeAddr(32, 0), 1'b0);
    wrChk("R5 last shared", routeAddr(31 + NUM_SHARED, 0), 1'b0, 64'h00AB_CDEF);
    rdChk("R5 last shared read", routeAddr(31 + NUM_SHARED, 0), 1'b0);
    wrChk("R7 beyond shared", routeAddr(32 + NUM_SHARED, 0), 1'b0, 64'h0012_3456);
    rdChk("R7 beyond shared read", routeAddr(32 + NUM_SHARED, 0), 1'b0);
    wrChk("R7 private", routeAddr(5, 0), 1'b0, 64'h0077_7777);
    rdChk("R7 private read", routeAddr(5, 0), 1'b0);
    rdChk("R7 private 31 read", routeAddr(31, 0), 1'b1);

    rdChk("R8 id2", 16'hFFE8, 1'b0);
    rdChk("R8 other id", 16'hFFE4, 1'b0);
    rdChk("R8 id window start", 16'hFFD0, 1'b0);
    wrChk("R8 id2 write", 16'hFFE8, 1'b0, 64'h0);
    rdChk("R8 id2 after write", 16'hFFE8, 1'b0);

    wrChk("R10 unmapped write", 16'h1000, 1'b0, 64'hFFFF_FFFF);
    rdChk("R10 unmapped read", 16'h1000, 1'b0);
    rdChk("R10 control unchanged", 16'h0000, 1'b0);

    @(posedge clk); #1;
    check("R9 idle rspValid", 64'(rspValid), 64'h0);
    check("R9 idle rspRdata", 64'(rspRdata), 64'h0);

    for (int i = 0; i < 600; i++) begin
      int kind = int'($urandom_range(0, 9));
      int n = int'($urandom_range(0, 32 + NUM_SHARED + 3));
      logic [63:0] d = {$urandom(), $urandom()};
      logic s8 = 1'($urandom_range(0, 1));
      if (kind < 3) wrChk("R5 R7 random write", routeAddr(n, 0), s8, d);
      else if (kind < 7) rdChk("R5 R7 random read", routeAddr(n, 0), s8);
      else if (kind == 7) wrChk("R2 random control", 16'h0000, 1'b0, d);
      else if (kind == 8) rdChk("R1 random control", 16'h0000, 1'b0);
      else wrChk("R6 random upper", routeAddr(n, 1), 1'b0, d);
    end
    for (int n = 32; n < 32 + NUM_SHARED; n++)
      rdChk("R5 sweep", routeAddr(n, 0), 1'b1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule